// File: doc/BRIEF.md
# Inversion-Coded Nonvolatile Write Controller

This controller sits between a host and a word-addressable nonvolatile memory array where programming a cell costs time and wears the cell. Each word in the array carries one extra flag cell that marks whether the stored pattern is the complement of the data it represents. A host write becomes a read-modify-write. The controller first fetches the stored pattern and its flag. It counts how many cells, flag included, would change if the new word were stored as-is and how many would change if its complement were stored. It then keeps whichever option costs fewer cells.

Only the cells that actually change are driven, through a per-bit write mask. If nothing changes, no array write is issued at all. A host read fetches the stored pattern and XORs it with the flag, so the host always sees the true data. The host side is a valid/ready request port with a one-cycle response pulse. The array side has a separate read strobe and write strobe, and read data returns a fixed number of cycles after the read strobe. The array's power-up content is all zero patterns with cleared flags.

Top module: `invwr_ctrl`

## Requirements
- R1: Every accepted request, read or write, issues exactly one one-cycle array read strobe, at the request's address, before any array write.
- R2: On a write, the stored pattern becomes the new word if its cost (differing data cells plus 1 if the old flag is set) is not above the cost of storing the complement (differing data cells plus 1 if the old flag is clear). Otherwise the stored pattern becomes the bitwise complement.
- R3: After a write, the word's flag cell is 1 exactly when the complement was stored, and 0 otherwise.
- R4: The write mask equals the XOR of the old and the new stored pattern, and the flag mask is 1 exactly when the flag value changes.
- R5: The response of a write reports the number of cells programmed (data plus flag). This count never exceeds (DATA_W+1)/2, rounded down.
- R6: A read returns the stored pattern XORed with DATA_W copies of the stored flag.
- R7: A write that would change no cell issues no array write strobe and reports a count of 0.
- R8: `req_ready` is low from the cycle after a request is accepted until its response cycle, so no second request is taken while one is in flight.
- R9: With RD_LAT the array read latency, a response comes RD_LAT+1 cycles after the accept edge for reads and for writes that change nothing, and RD_LAT+2 cycles after it for writes that program cells.
- R10: After reset, `req_ready` is 1, `resp_valid` is 0, and neither array strobe is active. A word never written reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Logical data to write |
| resp_valid | output | 1 | One-cycle pulse: request finished |
| resp_rdata | output | DATA_W | Decoded read data (reads) |
| resp_prog_cnt | output | CNT_W | Cells programmed by the write (0 for reads) |
| mem_rd_en | output | 1 | Array read strobe |
| mem_addr | output | ADDR_W | Array address for reads and writes |
| mem_rd_data | input | DATA_W | Stored pattern, valid RD_LAT cycles after the strobe edge |
| mem_rd_flag | input | 1 | Stored inversion flag, same timing as mem_rd_data |
| mem_wr_en | output | 1 | Array write strobe |
| mem_wr_data | output | DATA_W | Pattern to store |
| mem_wr_flag | output | 1 | Flag to store |
| mem_wr_mask | output | DATA_W | Per-bit program enable |
| mem_wr_flag_mask | output | 1 | Program enable for the flag cell |

## Verification
Counting from the clock edge that accepts a request, reads and no-change writes respond RD_LAT+1 edges later. Writes that program cells respond RD_LAT+2 edges later, and the array write lands on that same edge. The bench therefore counts edges after the accept, samples one time unit after each edge, and checks the response cycle number, the reported count and the array contents together at the first edge where the response shows up. Busy behaviour is sampled at every edge in between, and strobe counts are taken as differences across the whole request.

// File: rtl/invwr_ctrl.sv
module invwr_ctrl #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6,
  parameter int RD_LAT = 2,
  localparam int CNT_W = $clog2(DATA_W + 2),
  localparam int LAT_W = $clog2(RD_LAT + 1) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_rdata,
  output logic [CNT_W-1:0]  resp_prog_cnt,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  input  logic              mem_rd_flag,
  output logic              mem_wr_en,
  output logic [DATA_W-1:0] mem_wr_data,
  output logic              mem_wr_flag,
  output logic [DATA_W-1:0] mem_wr_mask,
  output logic              mem_wr_flag_mask
);

  localparam int HALF_CNT = (DATA_W + 1) / 2;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WAIT, ST_WR} state_t;

  state_t            state;
  logic              op_wr;
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] op_wdata;
  logic [LAT_W-1:0]  lat_cnt;

  function automatic logic [CNT_W-1:0] ones(input logic [DATA_W-1:0] v);
    logic [CNT_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < DATA_W; i++) acc = acc + CNT_W'(v[i]);
    return acc;
  endfunction

  logic [CNT_W-1:0]  n_diff, cost_raw, cost_inv, new_cnt;
  logic              pick_inv;
  logic [DATA_W-1:0] new_phys;
  logic              capture;

  assign n_diff   = ones(mem_rd_data ^ op_wdata);
  assign cost_raw = n_diff + CNT_W'(mem_rd_flag);
  assign cost_inv = CNT_W'(DATA_W) - n_diff + CNT_W'(!mem_rd_flag);
  assign pick_inv = cost_inv < cost_raw;
  assign new_phys = pick_inv ? ~op_wdata : op_wdata;
  assign new_cnt  = pick_inv ? cost_inv : cost_raw;
  assign capture  = (state == ST_WAIT) && (lat_cnt == LAT_W'(RD_LAT));

  assign req_ready = (state == ST_IDLE);
  assign mem_rd_en = (state == ST_RD);
  assign mem_wr_en = (state == ST_WR);
  assign mem_addr  = op_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state            <= ST_IDLE;
      op_wr            <= 1'b0;
      op_addr          <= '0;
      op_wdata         <= '0;
      lat_cnt          <= '0;
      resp_valid       <= 1'b0;
      resp_rdata       <= '0;
      resp_prog_cnt    <= '0;
      mem_wr_data      <= '0;
      mem_wr_flag      <= 1'b0;
      mem_wr_mask      <= '0;
      mem_wr_flag_mask <= 1'b0;
    end else begin
      resp_valid <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid) begin
          op_wr    <= req_write;
          op_addr  <= req_addr;
          op_wdata <= req_wdata;
          state    <= ST_RD;
        end
        ST_RD: begin
          lat_cnt <= LAT_W'(1);
          state   <= ST_WAIT;
        end
        ST_WAIT: begin
          lat_cnt <= lat_cnt + LAT_W'(1);
          if (capture) begin
            if (!op_wr) begin
              resp_rdata    <= mem_rd_data ^ {DATA_W{mem_rd_flag}};
              resp_prog_cnt <= '0;
              resp_valid    <= 1'b1;
              state         <= ST_IDLE;
            end else if (new_cnt == '0) begin
              resp_prog_cnt <= '0;
              resp_valid    <= 1'b1;
              state         <= ST_IDLE;
            end else begin
              mem_wr_data      <= new_phys;
              mem_wr_flag      <= pick_inv;
              mem_wr_mask      <= mem_rd_data ^ new_phys;
              mem_wr_flag_mask <= mem_rd_flag ^ pick_inv;
              resp_prog_cnt    <= new_cnt;
              state            <= ST_WR;
            end
          end
        end
        ST_WR: begin
          resp_valid <= 1'b1;
          state      <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en); // R1

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_prog_cnt <= CNT_W'(HALF_CNT))); // R5

  AST_WR_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> ((mem_wr_mask != '0) || mem_wr_flag_mask)); // R7

  AST_WR_COUNT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> ($countones({mem_wr_mask, mem_wr_flag_mask}) == int'(resp_prog_cnt))); // R4

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en || mem_wr_en) |-> !req_ready); // R8

  AST_RESP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (req_ready && !mem_rd_en && !mem_wr_en)); // R9

endmodule

// File: tb/test_invwr_ctrl.sv
module test_invwr_ctrl;
  localparam int DW  = 16;
  localparam int AW  = 6;
  localparam int LAT = 2;
  localparam int CW  = $clog2(DW + 2);
  localparam int NW  = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, resp_valid;
  logic [DW-1:0] resp_rdata;
  logic [CW-1:0] resp_prog_cnt;
  logic          mem_rd_en, mem_wr_en, mem_rd_flag, mem_wr_flag, mem_wr_flag_mask;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rd_data, mem_wr_data, mem_wr_mask;

  invwr_ctrl #(.DATA_W(DW), .ADDR_W(AW), .RD_LAT(LAT)) i_invwr_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata), .resp_prog_cnt(resp_prog_cnt),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .mem_rd_data(mem_rd_data), .mem_rd_flag(mem_rd_flag),
    .mem_wr_en(mem_wr_en), .mem_wr_data(mem_wr_data), .mem_wr_flag(mem_wr_flag),
    .mem_wr_mask(mem_wr_mask), .mem_wr_flag_mask(mem_wr_flag_mask)
  );

  // Behavioural array: zero patterns and clear flags after reset.
  logic [DW-1:0] arr_d [NW];
  logic          arr_f [NW];
  logic [DW:0]   rpipe [LAT];
  int            rd_strobes = 0, wr_strobes = 0;
  logic [AW-1:0] last_rd_addr;
  logic [DW-1:0] last_mask;
  logic          last_fmask;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) begin arr_d[i] <= '0; arr_f[i] <= 1'b0; end
      for (int i = 0; i < LAT; i++) rpipe[i] <= '0;
    end else begin
      if (mem_rd_en) begin
        rpipe[0]     <= {arr_f[mem_addr], arr_d[mem_addr]};
        rd_strobes   <= rd_strobes + 1;
        last_rd_addr <= mem_addr;
      end
      for (int i = 1; i < LAT; i++) rpipe[i] <= rpipe[i-1];
      if (mem_wr_en) begin
        arr_d[mem_addr] <= (arr_d[mem_addr] & ~mem_wr_mask) | (mem_wr_data & mem_wr_mask);
        if (mem_wr_flag_mask) arr_f[mem_addr] <= mem_wr_flag;
        wr_strobes <= wr_strobes + 1;
        last_mask  <= mem_wr_mask;
        last_fmask <= mem_wr_flag_mask;
      end
    end
  end
  assign {mem_rd_flag, mem_rd_data} = rpipe[LAT-1];

  int n_checks = 0, n_fail = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  function automatic int popc(input logic [DW-1:0] v);
    int c = 0;
    for (int i = 0; i < DW; i++) c += int'(v[i]);
    return c;
  endfunction

  // Issue one request; returns response edge count and whether ready rose early.
  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] v,
                       input bit nag, output int n, output bit busy_ok);
    wait (req_ready);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = v;
    @(posedge clk); #1;
    if (nag) begin req_addr = a + 1'b1; req_wdata = ~v; end
    else req_valid = 1'b0;
    busy_ok = !req_ready;
    n = 0;
    while (n < 50) begin
      @(posedge clk); #1; n++;
      if (resp_valid) break;
      if (req_ready) busy_ok = 1'b0;
    end
    req_valid = 1'b0;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] v, input bit nag);
    logic [DW-1:0] old_d, exp_d;
    logic old_f, inv;
    int c_raw, c_inv, c, n, r0, w0;
    bit busy_ok;
    old_d = arr_d[a]; old_f = arr_f[a];
    c_raw = popc(old_d ^ v) + int'(old_f);
    c_inv = popc(old_d ^ ~v) + int'(!old_f);
    inv   = c_inv < c_raw;
    c     = inv ? c_inv : c_raw;
    exp_d = inv ? ~v : v;
    r0 = rd_strobes; w0 = wr_strobes;
    issue(1'b1, a, v, nag, n, busy_ok);
    check(n == (c != 0 ? LAT + 2 : LAT + 1), "R9 write latency", n, c != 0 ? LAT + 2 : LAT + 1);
    check(rd_strobes - r0 == 1 && last_rd_addr == a, "R1 one read at address", rd_strobes - r0, 1);
    check(arr_d[a] == exp_d, "R2 stored pattern", arr_d[a], exp_d);
    check(arr_f[a] == inv, "R3 stored flag", arr_f[a], inv);
    check(int'(resp_prog_cnt) == c && c <= (DW + 1) / 2, "R5 programmed count", resp_prog_cnt, c);
    check(wr_strobes - w0 == (c != 0 ? 1 : 0), "R7 write strobe count", wr_strobes - w0, c != 0);
    if (c != 0) begin
      check(last_mask == (old_d ^ exp_d), "R4 data mask", last_mask, old_d ^ exp_d);
      check(last_fmask == (old_f ^ inv), "R4 flag mask", last_fmask, old_f ^ inv);
    end
    check(busy_ok, "R8 ready low while busy", busy_ok, 1);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp_v, input string req);
    int n, r0, w0;
    bit busy_ok;
    r0 = rd_strobes; w0 = wr_strobes;
    issue(1'b0, a, '0, 1'b0, n, busy_ok);
    check(n == LAT + 1, "R9 read latency", n, LAT + 1);
    check(rd_strobes - r0 == 1 && wr_strobes == w0, "R1 read-only strobes", rd_strobes - r0, 1);
    check(resp_rdata == exp_v, req, resp_rdata, exp_v);
    check(resp_rdata == (arr_d[a] ^ {DW{arr_f[a]}}), "R6 decode of stored word",
          resp_rdata, arr_d[a] ^ {DW{arr_f[a]}});
    check(busy_ok, "R8 ready low during read", busy_ok, 1);
  endtask

  task automatic t_reset();
    #1;
    check(req_ready == 1'b1, "R10 ready in reset", req_ready, 1);
    check(resp_valid == 1'b0, "R10 no response in reset", resp_valid, 0);
    check(!mem_rd_en && !mem_wr_en, "R10 strobes idle", {mem_rd_en, mem_wr_en}, 0);
  endtask

  task automatic t_fresh_read();
    do_read(6'd5, '0, "R10 unwritten word reads zero");
  endtask

  task automatic t_corner_writes();
    do_write(6'd1, 16'hFFFF, 1'b0);          // inverted, flag only
    do_read(6'd1, 16'hFFFF, "R6 inverted word");
    do_write(6'd1, 16'h0000, 1'b0);          // flag clears
    do_read(6'd1, 16'h0000, "R6 raw word");
    do_write(6'd1, 16'h0000, 1'b0);          // nothing changes
    do_write(6'd2, 16'h01FF, 1'b0);          // complement cheaper, max count
    do_read(6'd2, 16'h01FF, "R6 max-count word");
    do_write(6'd3, 16'h00FF, 1'b0);          // raw cheaper by one
    do_read(6'd3, 16'h00FF, "R6 half-width word");
  endtask

  task automatic t_busy_hold();
    do_write(6'd9, 16'hA5A5, 1'b1);          // host keeps valid high while busy
    do_read(6'd10, 16'h0000, "R8 held request not taken early");
  endtask

  task automatic t_sweep();
    logic [DW-1:0] shadow [NW];
    logic [15:0] lfsr = 16'hACE1;
    for (int i = 0; i < NW; i++) shadow[i] = arr_d[i] ^ {DW{arr_f[i]}};
    for (int k = 0; k < 60; k++) begin
      logic [AW-1:0] a;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = lfsr[AW-1:0] & 6'h07;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      do_write(a, lfsr, 1'b0);
      shadow[a] = lfsr;
      do_read(a, shadow[a], "R6 sweep read-back");
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    rst_n = 1'b1;
    @(posedge clk); #1;
    t_fresh_read();
    t_corner_writes();
    t_busy_hold();
    t_sweep();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule